// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Operations

This block controls a port of general-purpose pins and is reached over a simple single-cycle register bus. The bus has an address, a write enable, write data and combinational read data. Software keeps an output level register and a direction register.

Three write-only alias offsets set, clear or invert any chosen group of output bits in one bus write. No read-modify-write is needed, so two agents sharing the port cannot overwrite each other's bits. A read-only offset returns the synchronized level of every pin.

The pins drive a per-pin level and a per-pin output enable. The block accepts three inputs:
- the raw pin levels;
- a mask of pins that are currently assigned to a digital function;
- a port-wide enable that stalls input sampling.

Pins that are not built on a given die are described by a parameter mask. Those pins always read as zero.

Top module: `gpio_port`

## Requirements
- R1: After reset the output level register and the direction register are zero. All pin enables and pin levels are 0, and every offset reads 0.
- R2: A write to byte offset 0x00 loads the output level register, which reads back at 0x00. `pin_out` shows the new value from the clock edge that accepts the write.
- R3: A write to offset 0x04 drives to 1 every output level bit whose write-data bit is 1. The other bits are unchanged.
- R4: A write to offset 0x08 drives to 0 every output level bit whose write-data bit is 1. The other bits are unchanged.
- R5: A write to offset 0x0C inverts every output level bit whose write-data bit is 1. The other bits are unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C return 0.
- R7: Offset 0x14 holds the direction register and reads it back. A 1 makes the pin an output, and `pin_oe` equals this register.
- R8: Offset 0x10 returns the pin levels through a two-register path. A level on `pin_in` is visible there two clock edges after it is applied.
- R9: A bit of offset 0x10 reads 0 when its `pin_func_en` bit is 0. It also reads 0 when the pin is cleared in the `IMPL_MASK` parameter.
- R10: While `port_en` is 0 the captured input value does not change. When the port is enabled again, sampling resumes.
- R11: Writes to offset 0x10 and to unmapped offsets change no register. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr`, combinational |
| pin_in | input | W | Raw pin levels |
| pin_func_en | input | W | 1 where the pin is assigned to a digital function |
| port_en | input | 1 | Enables input sampling |
| pin_out | output | W | Output level per pin |
| pin_oe | output | W | Output enable per pin |

## Verification
Overlapping and disjoint patterns are applied in turn at the set, clear and toggle offsets:
- runs of ones, alternating nibbles and a zero mask;
- each pattern applied on top of a known output level.

These patterns tell the three operations apart from one another and from a plain load. The bench then runs a long mixed sequence of writes that are derived from the loop index. In this sequence the pin levels, the function mask and the port enable all change at the same time. A cycle-accurate model of the output level, the direction and the input capture checks the read data and both pin vectors on every clock. This exposes one-cycle errors in the synchronizer and errors in where the freeze or the mask takes effect. Writes to the input offset and to unmapped offsets are mixed in, and the outputs are checked after each of them.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Byte offsets of the register window.
  localparam int unsigned OFS_LEVEL = 32'h00;
  localparam int unsigned OFS_SET   = 32'h04;
  localparam int unsigned OFS_CLR   = 32'h08;
  localparam int unsigned OFS_INV   = 32'h0C;
  localparam int unsigned OFS_SENSE = 32'h10;
  localparam int unsigned OFS_DIR   = 32'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_ALIAS,
    SEL_SENSE,
    SEL_DIR
  } gp_rsel_e;

  typedef struct packed {
    logic level;
    logic set;
    logic clr;
    logic inv;
    logic dir;
  } gp_wr_s;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output gp_wr_s            wr,
  output gp_rsel_e          rsel
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    wr       = '0;
    wr.level = we && hit(addr, OFS_LEVEL);
    wr.set   = we && hit(addr, OFS_SET);
    wr.clr   = we && hit(addr, OFS_CLR);
    wr.inv   = we && hit(addr, OFS_INV);
    wr.dir   = we && hit(addr, OFS_DIR);
  end

  always_comb begin
    if (hit(addr, OFS_LEVEL))
      rsel = SEL_LEVEL;
    else if (hit(addr, OFS_SET) || hit(addr, OFS_CLR) || hit(addr, OFS_INV))
      rsel = SEL_ALIAS;
    else if (hit(addr, OFS_SENSE))
      rsel = SEL_SENSE;
    else if (hit(addr, OFS_DIR))
      rsel = SEL_DIR;
    else
      rsel = SEL_NONE;
  end

endmodule

// File: rtl/gpio_port_outreg.sv
module gpio_port_outreg
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  gp_wr_s       wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] level_q,
  output logic [W-1:0] dir_q
);

  // Next output level for one bus cycle; the write strobes are mutually exclusive.
  function automatic logic [W-1:0] next_level(input logic [W-1:0] cur,
                                               input gp_wr_s      w,
                                               input logic [W-1:0] d);
    logic [W-1:0] n;
    n = cur;
    if (w.level) n = d;
    if (w.set)   n = cur | d;
    if (w.clr)   n = cur & ~d;
    if (w.inv)   n = cur ^ d;
    return n;
  endfunction

  logic [W-1:0] level_d;
  assign level_d = next_level(level_q, wr, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      dir_q   <= '0;
    end else begin
      level_q <= level_d;
      if (wr.dir) dir_q <= wdata;
    end
  end

endmodule

// File: rtl/gpio_port_insamp.sv
module gpio_port_insamp #(
  parameter int unsigned W         = 32,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] func_en,
  input  logic         port_en,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] view
);

  logic [W-1:0] meta_q;

  function automatic logic [W-1:0] visible(input logic [W-1:0] c, input logic [W-1:0] f);
    return c & f & IMPL_MASK;
  endfunction

  // The first stage always runs; the second stage is the capture register and holds while disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cap_q  <= '0;
    end else begin
      meta_q <= pin_in;
      if (port_en) cap_q <= meta_q;
    end
  end

  assign view = visible(cap_q, func_en);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned  W         = 32,
  parameter int unsigned  ADDR_W    = 5,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  input  logic [W-1:0]      pin_func_en,
  input  logic              port_en,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe
);

  gp_wr_s       wr;
  gp_rsel_e     rsel;
  logic [W-1:0] level_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] in_cap;
  logic [W-1:0] in_view;

  gpio_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .we   (bus_we),
    .wr   (wr),
    .rsel (rsel)
  );

  gpio_port_outreg #(.W(W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr),
    .wdata   (bus_wdata),
    .level_q (level_q),
    .dir_q   (dir_q)
  );

  gpio_port_insamp #(.W(W), .IMPL_MASK(IMPL_MASK)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .func_en (pin_func_en),
    .port_en (port_en),
    .cap_q   (in_cap),
    .view    (in_view)
  );

  always_comb begin
    unique case (rsel)
      SEL_LEVEL: bus_rdata = level_q;
      SEL_SENSE: bus_rdata = in_view;
      SEL_DIR:   bus_rdata = dir_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign pin_out = level_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic              port_en,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic [W-1:0]      in_cap
);

  logic wr_set, wr_clr, wr_inv, wr_dir, wr_lvl, wr_none, rd_alias;
  assign wr_set   = bus_we && bus_addr == ADDR_W'(32'h04);
  assign wr_clr   = bus_we && bus_addr == ADDR_W'(32'h08);
  assign wr_inv   = bus_we && bus_addr == ADDR_W'(32'h0C);
  assign wr_dir   = bus_we && bus_addr == ADDR_W'(32'h14);
  assign wr_lvl   = bus_we && bus_addr == ADDR_W'(32'h00);
  assign wr_none  = !(wr_set || wr_clr || wr_inv || wr_dir || wr_lvl);
  assign rd_alias = bus_addr == ADDR_W'(32'h04) || bus_addr == ADDR_W'(32'h08) ||
                    bus_addr == ADDR_W'(32'h0C);

  a_r2_level_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lvl |=> pin_out == $past(bus_wdata));

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

  a_r5_invert_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inv |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));

  a_r6_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_alias |-> bus_rdata == '0);

  a_r7_oe_only_on_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));

  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(in_cap));

  a_r11_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_none |=> $stable(pin_out) && $stable(pin_oe));

endmodule

bind gpio_port gpio_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .port_en   (port_en),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .in_cap    (in_cap)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

  localparam int unsigned W      = 32;
  localparam int unsigned ADDR_W = 5;
  localparam logic [W-1:0] IMPL  = 32'h7FFF_FFFF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [W-1:0]      bus_wdata = '0;
  logic [W-1:0]      bus_rdata;
  logic [W-1:0]      pin_in = '0;
  logic [W-1:0]      pin_func_en = '1;
  logic              port_en = 1'b1;
  logic [W-1:0]      pin_out;
  logic [W-1:0]      pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural reference state
  logic [W-1:0] m_lvl = '0, m_dir = '0, m_s1 = '0, m_in = '0;

  always #5 clk = ~clk;

  gpio_port #(.W(W), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_func_en(pin_func_en), .port_en(port_en), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] m_read(input int a);
    case (a)
      'h00:    return m_lvl;
      'h10:    return m_in & pin_func_en & IMPL;
      'h14:    return m_dir;
      default: return '0;
    endcase
  endfunction

  // One bus cycle, started at a falling edge: check the read, advance the model, check the pins.
  task automatic cyc(input int a, input bit we, input logic [W-1:0] d, input string tag);
    bus_addr = ADDR_W'(a); bus_we = we; bus_wdata = d;
    #1;
    check(tag, bus_rdata, m_read(a));
    if (we) begin
      case (a)
        'h00: m_lvl = d;
        'h04: m_lvl = m_lvl | d;
        'h08: m_lvl = m_lvl & ~d;
        'h0C: m_lvl = m_lvl ^ d;
        'h14: m_dir = d;
        default: ;
      endcase
    end
    if (port_en) m_in = m_s1;
    m_s1 = pin_in;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    check("R2 pin_out", pin_out, m_lvl);
    check("R7 pin_oe", pin_oe, m_dir);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on pins and on every offset
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_oe", pin_oe, '0);
    for (int a = 0; a <= 'h14; a += 4) cyc(a, 1'b0, '0, "R1 read");

    cyc('h00, 1'b1, 32'hA5A5_5A5A, "R2");
    cyc('h00, 1'b0, '0, "R2 readback");
    cyc('h04, 1'b1, 32'h0000_FFFF, "R3");
    cyc('h00, 1'b0, '0, "R3 readback");
    cyc('h04, 1'b1, 32'h0000_0000, "R3 zero mask");
    cyc('h08, 1'b1, 32'hFF00_000F, "R4");
    cyc('h00, 1'b0, '0, "R4 readback");
    cyc('h0C, 1'b1, 32'hF0F0_F0F0, "R5");
    cyc('h0C, 1'b1, 32'h0000_0001, "R5 single bit");
    cyc('h00, 1'b0, '0, "R5 readback");
    cyc('h04, 1'b0, '0, "R6 set read");
    cyc('h08, 1'b0, '0, "R6 clear read");
    cyc('h0C, 1'b0, '0, "R6 invert read");
    cyc('h14, 1'b1, 32'h00FF_00F0, "R7");
    cyc('h14, 1'b0, '0, "R7 readback");

    // R8: two-edge input latency
    pin_in = 32'hDEAD_BEEF;
    cyc('h10, 1'b0, '0, "R8 edge0");
    cyc('h10, 1'b0, '0, "R8 edge1");
    cyc('h10, 1'b0, '0, "R8 edge2");
    pin_in = 32'hFFFF_FFFF;
    cyc('h10, 1'b0, '0, "R8 change");
    cyc('h10, 1'b0, '0, "R8 settle");
    cyc('h10, 1'b0, '0, "R9 top pin not implemented");
    pin_func_en = 32'h0F0F_00FF;
    cyc('h10, 1'b0, '0, "R9 function mask");
    pin_func_en = '1;

    // R10: freeze while disabled
    port_en = 1'b0;
    pin_in = 32'h1234_5678;
    for (int i = 0; i < 4; i++) cyc('h10, 1'b0, '0, "R10 frozen");
    port_en = 1'b1;
    cyc('h10, 1'b0, '0, "R10 resume");
    cyc('h10, 1'b0, '0, "R10 resumed");

    // R11: ignored writes and unmapped reads
    cyc('h10, 1'b1, 32'hFFFF_FFFF, "R11 write input offset");
    cyc('h18, 1'b1, 32'hFFFF_FFFF, "R11 unmapped write");
    cyc('h02, 1'b1, 32'h5555_5555, "R11 misaligned write");
    cyc('h1C, 1'b0, '0, "R11 unmapped read");
    cyc('h00, 1'b0, '0, "R11 level intact");
    cyc('h14, 1'b0, '0, "R11 dir intact");

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] v;
      int a;
      v = W'(i) * 32'h9E37_79B9 ^ (W'(i) << 7);
      a = ((i * 7) % 8) * 4;
      pin_in      = v ^ 32'h3C3C_0FF0;
      pin_func_en = (i % 5 == 0) ? 32'h00FF_FF00 : '1;
      port_en     = (i % 7) > 1;
      cyc(a, (i % 3) != 0, v, "R3 R4 R5 R8 R10 mixed");
    end

    done = 1'b1;
    report();
  end

endmodule